// File: doc/BRIEF.md
# Accumulator CPU Core

This block is a compact multi-cycle processor built around one 8-bit accumulator. Instructions and data share a single 32-byte address space. The memory array sits outside the block. The core drives a 5-bit address, the write data and a write strobe, and it samples 8-bit read data that the memory returns combinationally in the same cycle. Each instruction takes two active cycles. In the first, the core reads the instruction byte at the program counter and advances the counter. In the second, it carries out the operation, which may read or write one memory byte, change the accumulator or redirect the program counter.

Three one-hot states drive the sequencing:

- FETCH (001): reads the instruction.
- EXEC (010): carries it out.
- HALT (100): parks the core.

The transitions are:

- reset → FETCH.
- FETCH → EXEC on every enabled cycle.
- EXEC → FETCH for any instruction except the halt code.
- EXEC → HALT for the halt code.
- HALT → HALT until reset.

A run-enable input gates every transition. When it is low, all state stays as it is. The reset is synchronous and active high, and it takes priority over run enable.

Top module: `acc_cpu`

## Requirements
- R1: A cycle with `rst` high leaves PC, IR and ACC at zero and the state at FETCH. Afterwards `halted` is 0, `mem_addr` shows 0 and `mem_wdata` shows 0.
- R2: In FETCH, `mem_addr` equals PC. On an enabled edge, IR takes `mem_rdata`, PC increments modulo 32, and the state moves to EXEC.
- R3: In EXEC, IR[7:5] values 000, 010, 011, 100, 101 and 110 set ACC to, respectively: memory, ACC+memory, ACC−memory, ACC AND memory, ACC OR memory, and ACC XOR memory. The memory operand is read at `mem_addr` = IR[4:0]. All arithmetic is modulo 256.
- R4: `mem_wdata` always carries ACC. For IR[7:5]=001 in EXEC with `run_en` high, `mem_we` is 1 and `mem_addr`=IR[4:0]. `mem_we` is 0 in every other cycle.
- R5: IR[7:4]=1110 adds IR[3:0], zero-extended, to ACC.
- R6: The implied ACC codes are:
  - 0xF6: shift left by 1.
  - 0xF7: logical shift right by 1.
  - 0xF8: shift left by 4.
  - 0xF9: rotate left by 1.
  - 0xFA: rotate right by 1.
  - 0xFC: decrement.
  - 0xFD: clear.
  - 0xFE: bitwise invert.
- R7: The relative branches use the PC value that was already incremented in FETCH:
  - 0xF2: when ACC==0, PC+2.
  - 0xF3: when ACC==0, PC−3.
  - 0xF4: when ACC!=0, PC+2.
  - 0xF5: when ACC!=0, PC−3.

  A branch whose condition is false leaves PC unchanged.
- R8: 0xF0 loads PC from ACC[4:0]. 0xF1 loads PC from the old ACC[4:0] and loads ACC with the zero-extended incremented PC.
- R9: 0xFB reads memory at ACC[4:0] (`mem_addr`=ACC[4:0] in EXEC) into ACC.
- R10: 0xFF moves the core to HALT. There, `halted` is 1 and stays 1, and PC, IR, ACC and the outputs freeze until reset.
- R11: With `run_en` low, no register changes and `mem_we` is 0.
- R12: PC arithmetic wraps modulo 32, so fetching from address 31 is followed by a fetch from address 0.
- R13: In EXEC for any instruction that is neither a memory-operand op nor 0xFB, and in HALT, `mem_addr` shows PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Advances the core when high |
| mem_addr | output | 5 | Memory address for fetch, operand or indirect read |
| mem_wdata | output | 8 | Write data, always the accumulator |
| mem_we | output | 1 | Write strobe for the store instruction |
| mem_rdata | input | 8 | Combinational read data at `mem_addr` |
| halted | output | 1 | High while the core is in HALT |

## Verification
The hardest states to reach are taken backward branches and a halt that arrives while `run_en` is toggling. Both depend on the accumulator holding a particular value at the exact moment the branch or halt code is fetched. Directed memory images build count-down loops, a subroutine call followed by an indirect load, and a jump that runs the PC through 31 and back to 0. Many random memory images, run with randomly gated enable and periodic resets, then reach halt, wrap and branch outcomes that the directed images do not. A behavioural model of the instruction set predicts every output on every cycle.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W  = 8;
    localparam int BR_FWD = 2;
    localparam int BR_BWD = 3;

    typedef enum logic [2:0] {
        ST_FETCH = 3'b001,
        ST_EXEC  = 3'b010,
        ST_HALT  = 3'b100
    } cpu_state_e;

    typedef enum logic [4:0] {
        OP_LDA, OP_STA, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
        OP_ADDI,
        OP_JMP, OP_JSR, OP_BEQF, OP_BEQB, OP_BNEF, OP_BNEB,
        OP_SHL, OP_SHR, OP_SHL4, OP_ROL, OP_ROR,
        OP_LDAR, OP_DEC, OP_CLR, OP_INV, OP_HLT
    } op_e;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [OPC_W-1:0] ir,
    output op_e              op,
    output logic             uses_operand
);
    always_comb begin
        op           = OP_CLR;
        uses_operand = 1'b0;
        if (ir[7:5] != 3'b111) begin
            uses_operand = 1'b1;
            unique case (ir[7:5])
                3'd0:    op = OP_LDA;
                3'd1:    op = OP_STA;
                3'd2:    op = OP_ADD;
                3'd3:    op = OP_SUB;
                3'd4:    op = OP_AND;
                3'd5:    op = OP_OR;
                default: op = OP_XOR;
            endcase
        end else if (ir[4] == 1'b0) begin
            op = OP_ADDI;
        end else begin
            unique case (ir[3:0])
                4'h0: op = OP_JMP;
                4'h1: op = OP_JSR;
                4'h2: op = OP_BEQF;
                4'h3: op = OP_BEQB;
                4'h4: op = OP_BNEF;
                4'h5: op = OP_BNEB;
                4'h6: op = OP_SHL;
                4'h7: op = OP_SHR;
                4'h8: op = OP_SHL4;
                4'h9: op = OP_ROL;
                4'hA: op = OP_ROR;
                4'hB: op = OP_LDAR;
                4'hC: op = OP_DEC;
                4'hD: op = OP_CLR;
                4'hE: op = OP_INV;
                4'hF: op = OP_HLT;
            endcase
        end
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] rdata,
    input  logic [3:0]        imm,
    input  logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc_next,
    output logic              acc_load
);
    always_comb begin
        acc_next = acc;
        acc_load = 1'b1;
        unique case (op)
            OP_LDA, OP_LDAR: acc_next = rdata;
            OP_ADD:  acc_next = acc + rdata;
            OP_SUB:  acc_next = acc - rdata;
            OP_AND:  acc_next = acc & rdata;
            OP_OR:   acc_next = acc | rdata;
            OP_XOR:  acc_next = acc ^ rdata;
            OP_ADDI: acc_next = acc + DATA_W'(imm);
            OP_JSR:  acc_next = DATA_W'(pc);
            OP_SHL:  acc_next = acc << 1;
            OP_SHR:  acc_next = acc >> 1;
            OP_SHL4: acc_next = acc << 4;
            OP_ROL:  acc_next = {acc[DATA_W-2:0], acc[DATA_W-1]};
            OP_ROR:  acc_next = {acc[0], acc[DATA_W-1:1]};
            OP_DEC:  acc_next = acc - DATA_W'(1);
            OP_CLR:  acc_next = '0;
            OP_INV:  acc_next = ~acc;
            default: acc_load = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_pcgen.sv
module acc_cpu_pcgen
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] pc_next,
    output logic              pc_load
);
    logic acc_zero;
    assign acc_zero = (acc == '0);

    always_comb begin
        pc_next = pc;
        pc_load = 1'b0;
        unique case (op)
            OP_JMP, OP_JSR: begin
                pc_next = acc[ADDR_W-1:0];
                pc_load = 1'b1;
            end
            OP_BEQF: begin
                pc_next = pc + ADDR_W'(BR_FWD);
                pc_load = acc_zero;
            end
            OP_BEQB: begin
                pc_next = pc - ADDR_W'(BR_BWD);
                pc_load = acc_zero;
            end
            OP_BNEF: begin
                pc_next = pc + ADDR_W'(BR_FWD);
                pc_load = !acc_zero;
            end
            OP_BNEB: begin
                pc_next = pc - ADDR_W'(BR_BWD);
                pc_load = !acc_zero;
            end
            default: pc_load = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       is_halt_op,
    output cpu_state_e state_q
);
    cpu_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC:  state_d = is_halt_op ? ST_HALT : ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else if (run_en) begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);
    cpu_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [OPC_W-1:0]  ir_q;
    logic [DATA_W-1:0] acc_q;

    op_e               op;
    logic              uses_operand;
    logic [DATA_W-1:0] acc_next;
    logic              acc_load;
    logic [ADDR_W-1:0] pc_next;
    logic              pc_load;

    acc_cpu_decode u_dec (
        .ir           (ir_q),
        .op           (op),
        .uses_operand (uses_operand)
    );

    acc_cpu_alu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_alu (
        .op       (op),
        .acc      (acc_q),
        .rdata    (mem_rdata),
        .imm      (ir_q[3:0]),
        .pc       (pc_q),
        .acc_next (acc_next),
        .acc_load (acc_load)
    );

    acc_cpu_pcgen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pc (
        .op      (op),
        .pc      (pc_q),
        .acc     (acc_q),
        .pc_next (pc_next),
        .pc_load (pc_load)
    );

    acc_cpu_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .is_halt_op (op == OP_HLT),
        .state_q    (state_q)
    );

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            acc_q <= '0;
        end else if (run_en) begin
            unique case (state_q)
                ST_FETCH: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + ADDR_W'(1);
                end
                ST_EXEC: begin
                    if (acc_load) acc_q <= acc_next;
                    if (pc_load)  pc_q  <= pc_next;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr = pc_q;
        mem_we   = 1'b0;
        unique case (state_q)
            ST_FETCH: mem_addr = pc_q;
            ST_EXEC: begin
                if (uses_operand) begin
                    mem_addr = ir_q[ADDR_W-1:0];
                end else if (op == OP_LDAR) begin
                    mem_addr = acc_q[ADDR_W-1:0];
                end
                mem_we = run_en && (op == OP_STA);
            end
            default: mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = acc_q;
    assign halted    = (state_q == ST_HALT);

endmodule

// File: rtl/acc_cpu_sva.sv
module acc_cpu_sva #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic              mem_we,
    input logic              halted,
    input logic [2:0]        state_q,
    input logic [ADDR_W-1:0] pc_q,
    input logic [DATA_W-1:0] acc_q,
    input logic [7:0]        ir_q
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (state_q == 3'b001 && pc_q == '0 && acc_q == '0 && ir_q == '0));

    a_r1_state_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1);

    a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == 3'b001 && run_en) |=>
            (state_q == 3'b010 && pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1))));

    a_r4_write_in_exec: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> state_q == 3'b010);

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_q) && $stable(acc_q) && $stable(ir_q)));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> ($stable(pc_q) && $stable(acc_q) && $stable(ir_q) && $stable(state_q)));

    a_r11_no_write: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !mem_we);
endmodule

bind acc_cpu acc_cpu_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .mem_we  (mem_we),
    .halted  (halted),
    .state_q (state_q),
    .pc_q    (pc_q),
    .acc_q   (acc_q),
    .ir_q    (ir_q)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [4:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] mem_rdata;
    logic       halted;

    logic [7:0] mem [32];
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model state
    int m_pc, m_ir, m_acc, m_ph;   // ph: 0 fetch, 1 execute, 2 halted
    bit m_valid = 0;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    acc_cpu uut (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic string tag_of();
        if (rst) return "R1";
        if (!run_en) return "R11";
        if (m_ph == 2) return "R10";
        if (m_ph == 0) return "R2";
        if (m_pc == 0) return "R12";
        if (m_ir < 'hE0) return ((m_ir >> 5) == 1) ? "R4" : "R3";
        if ((m_ir >> 4) == 'hE) return "R5";
        if (m_ir == 'hF0 || m_ir == 'hF1) return "R8";
        if (m_ir >= 'hF2 && m_ir <= 'hF5) return "R7";
        if (m_ir == 'hFB) return "R9";
        if (m_ir == 'hFF) return "R10";
        return "R6";
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (m_valid) begin
            int e_addr;
            string t;
            t = tag_of();
            if (m_ph != 1) e_addr = m_pc;
            else if (m_ir < 'hE0) e_addr = m_ir & 31;
            else if (m_ir == 'hFB) e_addr = m_acc & 31;
            else e_addr = m_pc;                          // R13
            chk((m_ph == 1 && m_ir >= 'hE0 && m_ir != 'hFB) ? "R13" : t,
                int'(mem_addr), e_addr);
            chk(t, int'(mem_we),
                (m_ph == 1 && run_en && !rst && (m_ir >> 5) == 1) ? 1 : 0);
            chk(t, int'(mem_wdata), m_acc);
            chk(t, int'(halted), (m_ph == 2) ? 1 : 0);
        end
    end

    // model step and memory write at the active edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_pc = 0; m_ir = 0; m_acc = 0; m_ph = 0; m_valid = 1;
        end else if (run_en && m_valid) begin
            if (m_ph == 0) begin
                m_ir = mem[m_pc];
                m_pc = (m_pc + 1) & 31;
                m_ph = 1;
            end else if (m_ph == 1) begin
                int r;
                m_ph = 0;
                r = mem[m_ir & 31];
                if (m_ir < 'hE0) begin
                    case (m_ir >> 5)
                        0: m_acc = r;
                        2: m_acc = m_acc + r;
                        3: m_acc = m_acc - r;
                        4: m_acc = m_acc & r;
                        5: m_acc = m_acc | r;
                        6: m_acc = m_acc ^ r;
                        default: ;
                    endcase
                end else if ((m_ir >> 4) == 'hE) begin
                    m_acc = m_acc + (m_ir & 15);
                end else begin
                    case (m_ir)
                        'hF0: m_pc = m_acc & 31;
                        'hF1: begin int t0; t0 = m_acc; m_acc = m_pc; m_pc = t0 & 31; end
                        'hF2: if (m_acc == 0) m_pc = m_pc + 2;
                        'hF3: if (m_acc == 0) m_pc = m_pc - 3;
                        'hF4: if (m_acc != 0) m_pc = m_pc + 2;
                        'hF5: if (m_acc != 0) m_pc = m_pc - 3;
                        'hF6: m_acc = m_acc << 1;
                        'hF7: m_acc = m_acc >> 1;
                        'hF8: m_acc = m_acc << 4;
                        'hF9: m_acc = (m_acc << 1) | (m_acc >> 7);
                        'hFA: m_acc = (m_acc >> 1) | (m_acc << 7);
                        'hFB: m_acc = mem[m_acc & 31];
                        'hFC: m_acc = m_acc - 1;
                        'hFD: m_acc = 0;
                        'hFE: m_acc = ~m_acc;
                        default: m_ph = 2;
                    endcase
                end
                m_acc = m_acc & 255;
                m_pc  = m_pc & 31;
            end
        end
        if (mem_we === 1'b1) mem[mem_addr] <= mem_wdata;
    end

    task automatic do_reset();
        @(posedge clk); #2;
        rst = 1'b1; run_en = 1'b0;
        @(posedge clk); #2;
        @(posedge clk); #2;
        rst = 1'b0;
    endtask

    task automatic run(int n, bit gated);
        for (int i = 0; i < n; i++) begin
            run_en = gated ? (($urandom % 4) != 0) : 1'b1;
            @(posedge clk); #2;
        end
        run_en = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    endtask

    // watchdog
    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        do_reset();
        @(negedge clk);
        chk("R1", int'(halted), 0);
        chk("R1", int'(mem_addr), 0);
        @(posedge clk); #2;

        // Program A: memory ops, immediate add, implied ACC ops, halt
        clear_mem();
        mem[0]  = 8'h14; mem[1]  = 8'h55; mem[2]  = 8'h76; mem[3]  = 8'h97;
        mem[4]  = 8'hB8; mem[5]  = 8'hD9; mem[6]  = 8'hE7; mem[7]  = 8'h3A;
        mem[8]  = 8'hF6; mem[9]  = 8'hF7; mem[10] = 8'hF8; mem[11] = 8'hF9;
        mem[12] = 8'hFA; mem[13] = 8'hFE; mem[14] = 8'hFC; mem[15] = 8'h3B;
        mem[16] = 8'hFD; mem[17] = 8'hFF;
        mem[20] = 8'h35; mem[21] = 8'h1C; mem[22] = 8'h08; mem[23] = 8'h7E;
        mem[24] = 8'h81; mem[25] = 8'h5A;
        do_reset();
        run(140, 1'b1);
        chk("R3", int'(mem[26]), 'h9A);
        chk("R6", int'(mem[27]), 'h5E);
        chk("R10", int'(halted), 1);
        run(6, 1'b0);
        chk("R10", int'(halted), 1);

        // Program B: subroutine call, indirect load, store, jump into halt
        clear_mem();
        mem[0]  = 8'hE9; mem[1]  = 8'hF1; mem[4]  = 8'hFF;
        mem[9]  = 8'hEF; mem[10] = 8'hFB; mem[11] = 8'hF2;
        mem[12] = 8'h3E; mem[13] = 8'hE4; mem[14] = 8'hF0;
        mem[17] = 8'h60;
        do_reset();
        run(60, 1'b1);
        chk("R9", int'(mem[30]), 'h60);
        chk("R8", int'(halted), 1);

        // Program C: forward and backward branches, endless loop
        clear_mem();
        mem[0]  = 8'hFD; mem[1]  = 8'hF2; mem[2]  = 8'hFF; mem[3]  = 8'hFF;
        mem[4]  = 8'hE3; mem[5]  = 8'hF4; mem[6]  = 8'hFF; mem[7]  = 8'hFF;
        mem[8]  = 8'hE0; mem[9]  = 8'hFC; mem[10] = 8'hF5; mem[11] = 8'hF3;
        do_reset();
        run(400, 1'b1);
        chk("R7", int'(halted), 0);

        // Program D: jump to the top of memory and wrap to zero
        clear_mem();
        mem[0] = 8'hEE; mem[1] = 8'hF6; mem[2] = 8'hF0;
        for (int i = 28; i < 32; i++) mem[i] = 8'hE1;
        do_reset();
        run(150, 1'b1);
        chk("R12", int'(halted), 0);

        // random memory images with gated enable
        for (int s = 0; s < 30; s++) begin
            for (int i = 0; i < 32; i++) mem[i] = 8'($urandom);
            do_reset();
            run(250, 1'b1);
        end

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule